// File: doc/BRIEF.md
# Infrared UART Pulse Codec

This block sits between a UART core and an infrared transceiver. On the transmit side it watches the UART serial output. It sends a logic 1 bit as an idle (low) pin level. It sends a logic 0 bit as one narrow active-high pulse that starts at the bit boundary. The pulse width is chosen by a 2-bit select as a fraction of the bit period. Timing comes from two single-cycle clock enables that run at 16 and 32 times the baud rate.

On the receive side, each narrow pulse from the transceiver is stretched back into a full-width low bit for the UART. When the block is disabled, both directions pass straight through so the UART can drive a wired line. The enable and the width select are captured in a configuration register that resets to zero.

Top module: `ir_pulse_codec`

## Requirements
- R1: The enable and width-select configuration is registered, resets to 0 and takes effect one clock after the inputs change, so during and right after reset the block is in bypass.
- R2: With the enable clear, `ir_tx_o` equals `uart_txd_i` and `uart_rxd_o` equals `ir_rx_i` in the same cycle.
- R3: With the enable set and `uart_txd_i` held high, `ir_tx_o` stays low.
- R4: With the enable set, a falling edge on `uart_txd_i` marks a bit boundary, and further boundaries follow every 16 ticks of the 16x enable. At every boundary where `uart_txd_i` is low, one high pulse starts on `ir_tx_o`, visible the cycle after the boundary clock edge.
- R5: Width select 00 gives a pulse lasting three 16x ticks (3/16 of a bit).
- R6: Width select 01 gives a pulse lasting one 16x tick (1/16 of a bit).
- R7: Width select 10 gives a pulse lasting one 32x tick (1/32 of a bit).
- R8: Width select 11 behaves as 00 (3/16 of a bit).
- R9: With the enable set, a rising edge on `ir_rx_i` passes a two-flop synchronizer and then drives `uart_rxd_o` low two clocks after the input rises. It stays low until 16 ticks of the 16x enable have passed, then returns high. The 32x enable has no effect on receive.
- R10: A new rising edge on `ir_rx_i` while `uart_rxd_o` is held low restarts the 16-tick hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Codec enable; 0 selects bypass |
| width_sel_i | input | 2 | Pulse width: 00 3/16, 01 1/16, 10 1/32, 11 3/16 |
| tick16_i | input | 1 | Single-cycle enable at 16x baud |
| tick32_i | input | 1 | Single-cycle enable at 32x baud |
| uart_txd_i | input | 1 | Serial data from UART transmitter |
| uart_rxd_o | output | 1 | Serial data to UART receiver |
| ir_tx_o | output | 1 | Pulse output to IR emitter, active high |
| ir_rx_i | input | 1 | Pulse input from IR detector, active high |

## Verification
The hardest case to reach is a pulse width measured exactly in clock cycles. That width depends on where the bit boundary falls relative to the tick enables. The stimulus therefore drops the UART line in the cycle where both enables are about to fire. Each width then maps to a fixed cycle count, and two back-to-back zero bits show the boundary repeating 16 ticks later. On receive, a second pulse is placed 32 clocks into the hold, again tick-aligned, so the restart appears as a precise total low time.

// File: rtl/ir_codec_pkg.sv
package ir_codec_pkg;
  typedef enum logic [1:0] {
    WSEL_3_16 = 2'b00,
    WSEL_1_16 = 2'b01,
    WSEL_1_32 = 2'b10,
    WSEL_ALT  = 2'b11
  } wsel_e;

  // pulse length in ticks of the selected enable
  function automatic int unsigned pulse_ticks(wsel_e sel, int unsigned long_ticks);
    return (sel == WSEL_3_16 || sel == WSEL_ALT) ? long_ticks : 1;
  endfunction

  function automatic logic uses_fast_tick(wsel_e sel);
    return sel == WSEL_1_32;
  endfunction
endpackage

// File: rtl/ir_cfg_reg.sv
module ir_cfg_reg
  import ir_codec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] width_sel_i,
  output logic       en_o,
  output wsel_e      sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      sel_o <= WSEL_3_16;
    end else begin
      en_o  <= en_i;
      sel_o <= wsel_e'(width_sel_i);
    end
  end
endmodule

// File: rtl/ir_tx_shaper.sv
module ir_tx_shaper
  import ir_codec_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned LONG_TICKS = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  wsel_e sel_i,
  input  logic  tick16_i,
  input  logic  tick32_i,
  input  logic  txd_i,
  output logic  pulse_o
);
  localparam int unsigned PW = $clog2(OSR);
  localparam int unsigned CW = $clog2(LONG_TICKS + 1);

  logic          txd_q;
  logic [PW-1:0] phase_q;
  logic [CW-1:0] pcnt_q;
  logic          pulse_q;
  logic          fall, wrap, start, step;
  logic [CW-1:0] len;

  assign fall  = txd_q & ~txd_i;
  assign wrap  = tick16_i && (phase_q == PW'(OSR - 1));
  assign start = en_i & ~txd_i & (fall | wrap);
  assign step  = uses_fast_tick(sel_i) ? tick32_i : tick16_i;
  assign len   = CW'(pulse_ticks(sel_i, LONG_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q   <= 1'b1;
      phase_q <= '0;
    end else begin
      txd_q <= txd_i;
      if (fall)          phase_q <= '0;
      else if (wrap)     phase_q <= '0;
      else if (tick16_i) phase_q <= phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      pcnt_q  <= '0;
    end else if (start) begin
      pulse_q <= 1'b1;
      pcnt_q  <= '0;
    end else if (pulse_q && step) begin
      if (pcnt_q == len - 1'b1) pulse_q <= 1'b0;
      else                      pcnt_q  <= pcnt_q + 1'b1;
    end
  end

  assign pulse_o = pulse_q;

  assert_pulse_on_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> $past(!txd_i && en_i));

  assert_short_ends_on_fast_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && sel_i == WSEL_1_32 && tick32_i && !start) |=> !pulse_q);

  assert_long_never_overruns_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (pcnt_q < CW'(LONG_TICKS)));
endmodule

// File: rtl/ir_rx_stretcher.sv
module ir_rx_stretcher #(
  parameter int unsigned HOLD_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick16_i,
  input  logic ir_i,
  output logic hold_o
);
  localparam int unsigned HW = $clog2(HOLD_TICKS);

  logic          s1_q, s2_q, hold_q;
  logic [HW-1:0] cnt_q;
  logic          edge_det;

  assign edge_det = s1_q & ~s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= ir_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (edge_det) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q && tick16_i) begin
      if (cnt_q == HW'(HOLD_TICKS - 1)) hold_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hold_o = hold_q;

  assert_hold_ends_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> $past(tick16_i));

  assert_hold_starts_after_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> $past(s1_q));

  assert_retrigger_restarts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && s1_q && !s2_q) |=> (hold_q && cnt_q == '0));
endmodule

// File: rtl/ir_pulse_codec.sv
module ir_pulse_codec
  import ir_codec_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned LONG_TICKS = 3,
  parameter int unsigned HOLD_TICKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] width_sel_i,
  input  logic       tick16_i,
  input  logic       tick32_i,
  input  logic       uart_txd_i,
  output logic       uart_rxd_o,
  output logic       ir_tx_o,
  input  logic       ir_rx_i
);
  logic  en_q, pulse, hold;
  wsel_e sel_q;

  ir_cfg_reg u_cfg (
    .clk_i, .rst_ni, .en_i, .width_sel_i,
    .en_o (en_q), .sel_o (sel_q)
  );

  ir_tx_shaper #(.OSR(OSR), .LONG_TICKS(LONG_TICKS)) u_tx (
    .clk_i, .rst_ni, .en_i (en_q), .sel_i (sel_q),
    .tick16_i, .tick32_i, .txd_i (uart_txd_i), .pulse_o (pulse)
  );

  ir_rx_stretcher #(.HOLD_TICKS(HOLD_TICKS)) u_rx (
    .clk_i, .rst_ni, .tick16_i, .ir_i (ir_rx_i), .hold_o (hold)
  );

  assign ir_tx_o    = en_q ? pulse : uart_txd_i;
  assign uart_rxd_o = en_q ? ~hold : ir_rx_i;

  assert_enabled_idle_line_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q) && uart_txd_i && $past(uart_txd_i) && !$past(pulse)) |-> !ir_tx_o);
endmodule

// File: tb/ir_pulse_codec_tb_top.sv
module ir_pulse_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [1:0] wsel = 2'b00;
  logic       txd = 1'b1;
  logic       irx = 1'b0;
  logic       rxd, itx;
  logic [7:0] tcnt = 8'd0;
  logic       t16, t32;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 8'd1;
  assign t16 = (tcnt[1:0] == 2'd3);
  assign t32 = tcnt[0];

  ir_pulse_codec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .width_sel_i(wsel),
    .tick16_i(t16), .tick32_i(t32), .uart_txd_i(txd),
    .uart_rxd_o(rxd), .ir_tx_o(itx), .ir_rx_i(irx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    en = 1'b1; txd = 1'b1; irx = 1'b0;
    wait_neg(3);
    chk(itx == 1'b1, "R1 bypass tx in reset", itx, 1);
    chk(rxd == 1'b0, "R1 bypass rx in reset", rxd, 0);
    rst_n = 1'b1;
    wait_neg(1);
    chk(itx == 1'b0, "R1 enabled tx after reset", itx, 0);
    chk(rxd == 1'b1, "R1 enabled rx after reset", rxd, 1);
  endtask

  task automatic test_bypass();
    en = 1'b0;
    wait_neg(2);
    txd = 1'b0; #1;
    chk(itx == 1'b0, "R2 tx low passthrough", itx, 0);
    txd = 1'b1; #1;
    chk(itx == 1'b1, "R2 tx high passthrough", itx, 1);
    irx = 1'b1; #1;
    chk(rxd == 1'b1, "R2 rx high passthrough", rxd, 1);
    irx = 1'b0; #1;
    chk(rxd == 1'b0, "R2 rx low passthrough", rxd, 0);
    en = 1'b1;
    wait_neg(2);
  endtask

  // two zero bits then one one bit, boundary aligned to both ticks
  task automatic test_tx(input logic [1:0] sel, input int width, input string req);
    int hi = 0, rises = 0, idle_hi = 0;
    logic prev = 1'b0, first = 1'b0, second = 1'b0;
    wsel = sel; txd = 1'b1;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (itx) idle_hi++;
    end
    chk(idle_hi == 0, "R3 idle high line gives no pulse", idle_hi, 0);
    while (tcnt[1:0] != 2'd3) @(negedge clk);
    txd = 1'b0;
    for (int i = 1; i <= 192; i++) begin
      @(negedge clk);
      if (itx) hi++;
      if (itx && !prev) rises++;
      prev = itx;
      if (i == 1)  first = itx;
      if (i == 65) second = itx;
      if (i == 128) txd = 1'b1;
    end
    chk(first == 1'b1, "R4 pulse at first boundary", first, 1);
    chk(second == 1'b1, "R4 pulse at next boundary", second, 1);
    chk(rises == 2, "R4 one pulse per zero bit", rises, 2);
    chk(hi == 2 * width, req, hi, 2 * width);
  endtask

  task automatic test_rx(input bit retrig, input int exp_low, input string req);
    int lows = 0;
    logic s1 = 1'b0, s2 = 1'b0;
    wsel = 2'b00;
    wait_neg(80);
    while (tcnt[1:0] != 2'd2) @(negedge clk);
    irx = 1'b1;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (!rxd) lows++;
      if (i == 1) s1 = rxd;
      if (i == 2) s2 = rxd;
      if (i == 2) irx = 1'b0;
      if (retrig && i == 32) irx = 1'b1;
      if (retrig && i == 34) irx = 1'b0;
    end
    chk(s1 == 1'b1, "R9 still high one clock after input", s1, 1);
    chk(s2 == 1'b0, "R9 low two clocks after input", s2, 0);
    chk(lows == exp_low, req, lows, exp_low);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_bypass();
    test_tx(2'b00, 12, "R5 3/16 width in cycles");
    test_tx(2'b01, 4,  "R6 1/16 width in cycles");
    test_tx(2'b10, 2,  "R7 1/32 width in cycles");
    test_tx(2'b11, 12, "R8 code 11 acts as 3/16");
    test_rx(1'b0, 64, "R9 hold lasts 16 slow ticks");
    test_rx(1'b1, 96, "R10 second edge restarts hold");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule